// File: doc/BRIEF.md
# Banked Data Pointer Register File

This block keeps two 16-bit data pointers and a one-bit select register inside the special-function-register (SFR) space of a small microcontroller core. Software reaches every byte through an 8-bit SFR port: an address, a write strobe, write data and a combinational read-data output. The pointer that the select bit picks is always presented on a 16-bit output, which an address generator uses for off-chip data accesses.

Three command inputs come from the core's instruction sequencer. One loads a 16-bit value into the selected pointer. One increments the selected pointer. One performs the read-modify-write increment of the select register, which flips the select bit. Because every pointer command follows the select bit, a block copy keeps its source address in one pointer and its destination in the other. A single select toggle moves between them, and neither address has to be saved and restored.

Top module: `dptr_bank`

## Requirements
- R1: A synchronous active-low reset clears both pointers to 0000h and the select bit to 0, overriding every other input in that cycle.
- R2: SFR 82h and 83h hold the low and high bytes of pointer 0, and 84h and 85h hold those of pointer 1. A write updates only the addressed byte at the next clock edge. A read returns the stored byte in the same cycle.
- R3: Bit 0 of SFR 86h is the select bit and a write sets it from write-data bit 0. Write-data bits 7:1 have no effect, and a read of 86h returns 0 in bits 7:1.
- R4: The pointer output and the select output show the pointer chosen by the select bit: pointer 0 when it is 0, pointer 1 when it is 1.
- R5: The increment command adds 1 to the selected pointer as a 16-bit value, carrying from the low byte into the high byte and wrapping from FFFFh to 0000h. The other pointer is left unchanged.
- R6: The load command writes the 16-bit load value into the selected pointer only.
- R7: The select-increment command flips the select bit at the next clock edge.
- R8: SFR writes to any address other than 82h to 86h change nothing, and reads at those addresses return 00h.
- R9: All commands in a cycle use the select value held before the clock edge. On the selected pointer, load takes precedence over increment, and increment takes precedence over an SFR byte write. An SFR write to 86h takes precedence over select-increment. An SFR write to the other pointer still takes effect in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sfr_addr | input | 8 | SFR address |
| sfr_wr | input | 1 | SFR write strobe |
| sfr_wdata | input | 8 | SFR write data |
| sfr_rdata | output | 8 | SFR read data for sfr_addr (combinational) |
| ptr_load | input | 1 | Load selected pointer from ptr_load_val |
| ptr_load_val | input | 16 | Value for ptr_load |
| ptr_inc | input | 1 | Increment selected pointer |
| sel_inc | input | 1 | Increment of the select register (toggles select) |
| ptr_out | output | 16 | Currently selected pointer |
| ptr_sel | output | 1 | Current select bit |

## Verification
Directed patterns come first. They load byte patterns through the SFR port, increment across the FFh low-byte carry and the FFFFh wrap, and write 86h with data whose upper bits are set. Each one separates a single failure: a wrong byte lane, a lost carry, upper select bits leaking into the register, or the wrong pointer being updated. Collision patterns then present load, increment and SFR writes together, with and without a select change in the same cycle. These show whether commands use the select value from before the edge and follow the stated precedence. A long pseudo-random mix of addresses, including unmapped neighbours 80h, 81h, 87h and 88h, is then compared against a behavioural model on every cycle.

// File: rtl/dptr_pkg.sv
// Package dptr_pkg
// Shared constants for the banked data pointer block. It assumes exactly two
// pointers, so that one select bit is enough to choose between them.
package dptr_pkg;
    localparam int NUM_PTR = 2;
    localparam int SEL_W   = 1;
endpackage

// File: rtl/dptr_reg.sv
// Module dptr_reg
// One pointer register made of two bytes. On each edge it applies, in this
// order of precedence: a 16-bit load, a 16-bit increment with wrap, or byte
// writes from the SFR port. It assumes the caller has already gated load and
// increment with "this pointer is selected".
module dptr_reg #(
    parameter int DATA_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load,
    input  logic [2*DATA_W-1:0] load_val,
    input  logic                inc,
    input  logic                wr_lo,
    input  logic                wr_hi,
    input  logic [DATA_W-1:0]   wdata,
    output logic [2*DATA_W-1:0] q
);
    localparam int PTR_W = 2 * DATA_W;

    logic [PTR_W-1:0] nxt;

    // Choose the next pointer value from the commands in precedence order.
    always_comb begin
        nxt = q;
        if (load) begin
            nxt = load_val;
        end else if (inc) begin
            nxt = q + PTR_W'(1);
        end else begin
            if (wr_lo) nxt[DATA_W-1:0]     = wdata;
            if (wr_hi) nxt[PTR_W-1:DATA_W] = wdata;
        end
    end

    // Hold the pointer; a synchronous reset clears it.
    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= nxt;
    end
endmodule

// File: rtl/dptr_sel.sv
// Module dptr_sel
// The select register. An SFR write loads bit 0 of the write data. Otherwise
// a select-increment command flips the bit. It assumes the write enable is
// already decoded for the select register's address.
module dptr_sel (
    input  logic clk,
    input  logic rst_n,
    input  logic wr,
    input  logic wbit,
    input  logic toggle,
    output logic sel
);
    // Update the select bit; a write takes precedence over a toggle.
    always_ff @(posedge clk) begin
        if (!rst_n)      sel <= 1'b0;
        else if (wr)     sel <= wbit;
        else if (toggle) sel <= ~sel;
    end
endmodule

// File: rtl/dptr_rdmux.sv
// Module dptr_rdmux
// Combinational SFR read mux. Pointer bytes sit in consecutive low/high
// address pairs starting at BASE_ADDR, and the select register follows them.
// Any other address reads as zero.
module dptr_rdmux #(
    parameter int                 DATA_W    = 8,
    parameter int                 ADDR_W    = 8,
    parameter int                 NUM_PTR   = 2,
    parameter logic [ADDR_W-1:0]  BASE_ADDR = 8'h82
) (
    input  logic [ADDR_W-1:0]                 addr,
    input  logic [NUM_PTR-1:0][2*DATA_W-1:0]  ptrs,
    input  logic                              sel,
    output logic [DATA_W-1:0]                 rdata
);
    localparam logic [ADDR_W-1:0] SEL_ADDR = BASE_ADDR + ADDR_W'(2 * NUM_PTR);

    // Decode the address and return the matching byte, or zero.
    always_comb begin
        rdata = '0;
        for (int i = 0; i < NUM_PTR; i++) begin
            if (addr == BASE_ADDR + ADDR_W'(2 * i))
                rdata = ptrs[i][DATA_W-1:0];
            if (addr == BASE_ADDR + ADDR_W'(2 * i + 1))
                rdata = ptrs[i][2*DATA_W-1:DATA_W];
        end
        if (addr == SEL_ADDR)
            rdata = DATA_W'(sel);
    end
endmodule

// File: rtl/dptr_bank.sv
// Module dptr_bank
// Two banked data pointers and a select register in SFR space. Load and
// increment commands are steered to the selected pointer, and that pointer is
// driven on ptr_out. It assumes the SFR port is accessed at most once per cycle.
module dptr_bank #(
    parameter int                DATA_W    = 8,
    parameter int                ADDR_W    = 8,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 8'h82
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   sfr_addr,
    input  logic                sfr_wr,
    input  logic [DATA_W-1:0]   sfr_wdata,
    output logic [DATA_W-1:0]   sfr_rdata,
    input  logic                ptr_load,
    input  logic [2*DATA_W-1:0] ptr_load_val,
    input  logic                ptr_inc,
    input  logic                sel_inc,
    output logic [2*DATA_W-1:0] ptr_out,
    output logic                ptr_sel
);
    import dptr_pkg::*;

    localparam int                PTR_W    = 2 * DATA_W;
    localparam logic [ADDR_W-1:0] SEL_ADDR = BASE_ADDR + ADDR_W'(2 * NUM_PTR);

    logic [NUM_PTR-1:0][PTR_W-1:0] ptr_q;
    logic                          sel_q;

    // One register per pointer, each with its own byte address pair.
    for (genvar g = 0; g < NUM_PTR; g++) begin : g_ptr
        localparam logic [ADDR_W-1:0] LO_ADDR = BASE_ADDR + ADDR_W'(2 * g);
        localparam logic [ADDR_W-1:0] HI_ADDR = BASE_ADDR + ADDR_W'(2 * g + 1);

        logic active;
        assign active = (sel_q == SEL_W'(g));

        dptr_reg #(.DATA_W(DATA_W)) u_reg (
            .clk      (clk),
            .rst_n    (rst_n),
            .load     (ptr_load && active),
            .load_val (ptr_load_val),
            .inc      (ptr_inc && active),
            .wr_lo    (sfr_wr && (sfr_addr == LO_ADDR)),
            .wr_hi    (sfr_wr && (sfr_addr == HI_ADDR)),
            .wdata    (sfr_wdata),
            .q        (ptr_q[g])
        );
    end

    dptr_sel u_sel (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr     (sfr_wr && (sfr_addr == SEL_ADDR)),
        .wbit   (sfr_wdata[0]),
        .toggle (sel_inc),
        .sel    (sel_q)
    );

    dptr_rdmux #(
        .DATA_W    (DATA_W),
        .ADDR_W    (ADDR_W),
        .NUM_PTR   (NUM_PTR),
        .BASE_ADDR (BASE_ADDR)
    ) u_rdmux (
        .addr  (sfr_addr),
        .ptrs  (ptr_q),
        .sel   (sel_q),
        .rdata (sfr_rdata)
    );

    assign ptr_out = ptr_q[sel_q];
    assign ptr_sel = sel_q;
endmodule

// File: rtl/dptr_bank_chk.sv
// Module dptr_bank_chk
// Port-level properties of dptr_bank, bound to every instance of it.
module dptr_bank_chk #(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic [ADDR_W-1:0]   sfr_addr,
    input logic                sfr_wr,
    input logic [DATA_W-1:0]   sfr_wdata,
    input logic [DATA_W-1:0]   sfr_rdata,
    input logic                ptr_load,
    input logic [2*DATA_W-1:0] ptr_load_val,
    input logic                ptr_inc,
    input logic                sel_inc,
    input logic [2*DATA_W-1:0] ptr_out,
    input logic                ptr_sel
);
    localparam int PTR_W = 2 * DATA_W;

    logic quiet;
    assign quiet = !sfr_wr && !ptr_load && !ptr_inc && !sel_inc;

    // Increment alone advances the visible pointer by one, with wrap.
    assert_inc_wraps_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr_inc && !ptr_load && !sel_inc && !sfr_wr)
        |=> ptr_out == PTR_W'($past(ptr_out) + PTR_W'(1)));

    // A load alone shows up on the pointer output.
    assert_load_active_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr_load && !sel_inc && !sfr_wr) |=> ptr_out == $past(ptr_load_val));

    // Select-increment without a write to 86h flips the select.
    assert_sel_toggle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_inc && !(sfr_wr && sfr_addr == 8'h86)) |=> ptr_sel != $past(ptr_sel));

    // A write to 86h takes bit 0 and beats select-increment (R9).
    assert_sel_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (sfr_wr && sfr_addr == 8'h86) |=> ptr_sel == $past(sfr_wdata[0]));

    // Upper bits of the select register read as zero.
    assert_sel_upper_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (sfr_addr == 8'h86) |-> sfr_rdata[DATA_W-1:1] == '0);

    // Unmapped addresses read zero.
    assert_unmapped_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (sfr_addr < 8'h82 || sfr_addr > 8'h86) |-> sfr_rdata == '0);

    // With no command, nothing visible changes.
    assert_idle_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
        quiet |=> ($stable(ptr_out) && $stable(ptr_sel)));
endmodule

bind dptr_bank dptr_bank_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .sfr_addr     (sfr_addr),
    .sfr_wr       (sfr_wr),
    .sfr_wdata    (sfr_wdata),
    .sfr_rdata    (sfr_rdata),
    .ptr_load     (ptr_load),
    .ptr_load_val (ptr_load_val),
    .ptr_inc      (ptr_inc),
    .sel_inc      (sel_inc),
    .ptr_out      (ptr_out),
    .ptr_sel      (ptr_sel)
);

// File: tb/test_dptr_bank.sv
`timescale 1ns/1ps
// Bench for dptr_bank. A behavioural model is stepped once per clock, and
// the outputs are compared with it on every cycle.
module test_dptr_bank;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [7:0]  sfr_addr;
    logic        sfr_wr;
    logic [7:0]  sfr_wdata;
    logic [7:0]  sfr_rdata;
    logic        ptr_load;
    logic [15:0] ptr_load_val;
    logic        ptr_inc;
    logic        sel_inc;
    logic [15:0] ptr_out;
    logic        ptr_sel;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    // Behavioural model state.
    int m_ptr[2];
    int m_sel;

    always #2.5 clk = ~clk;

    dptr_bank i_dptr_bank (
        .clk(clk), .rst_n(rst_n), .sfr_addr(sfr_addr), .sfr_wr(sfr_wr),
        .sfr_wdata(sfr_wdata), .sfr_rdata(sfr_rdata), .ptr_load(ptr_load),
        .ptr_load_val(ptr_load_val), .ptr_inc(ptr_inc), .sel_inc(sel_inc),
        .ptr_out(ptr_out), .ptr_sel(ptr_sel)
    );

    task automatic chk(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int model_read(int a);
        case (a)
            'h82: return m_ptr[0] & 'hFF;
            'h83: return (m_ptr[0] >> 8) & 'hFF;
            'h84: return m_ptr[1] & 'hFF;
            'h85: return (m_ptr[1] >> 8) & 'hFF;
            'h86: return m_sel;
            default: return 0;
        endcase
    endfunction

    // One cycle: compare the state outputs, drive the inputs, compare the
    // read data, then advance the model to the state after the next edge.
    task automatic cycle(bit rst, int a, bit wr, int wd, bit ld, int lv,
                         bit inc, bit sinc, string tag);
        int cur;
        int idx;
        @(negedge clk);
        if (!done) begin
            chk({tag, "/R4 ptr_out"}, ptr_out, m_ptr[m_sel]);
            chk({tag, "/R7 ptr_sel"}, ptr_sel, m_sel);
        end
        rst_n = !rst; sfr_addr = 8'(a); sfr_wr = wr; sfr_wdata = 8'(wd);
        ptr_load = ld; ptr_load_val = 16'(lv); ptr_inc = inc; sel_inc = sinc;
        #1;
        if (!rst && !done)
            chk((a == 'h86) ? "R3 read" : (a < 'h82 || a > 'h86) ? "R8 read" : "R2 read",
                sfr_rdata, model_read(a));
        if (rst) begin
            m_ptr[0] = 0; m_ptr[1] = 0; m_sel = 0;
        end else begin
            cur = m_sel;
            if (ld)       m_ptr[cur] = lv & 'hFFFF;
            else if (inc) m_ptr[cur] = (m_ptr[cur] + 1) & 'hFFFF;
            if (wr && a >= 'h82 && a <= 'h85) begin
                idx = (a - 'h82) / 2;
                if (!(idx == cur && (ld || inc))) begin
                    if ((a - 'h82) % 2 == 0) m_ptr[idx] = (m_ptr[idx] & 'hFF00) | (wd & 'hFF);
                    else                     m_ptr[idx] = (m_ptr[idx] & 'h00FF) | ((wd & 'hFF) << 8);
                end
            end
            if (wr && a == 'h86) m_sel = wd & 1;
            else if (sinc)       m_sel = m_sel ^ 1;
        end
    endtask

    task automatic idle(string tag);
        cycle(0, 'h00, 0, 0, 0, 0, 0, 0, tag);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    // Watchdog: an expired run counts as one failed check.
    initial begin
        #(5ns * 100000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        m_ptr[0] = 0; m_ptr[1] = 0; m_sel = 0;
        // R1: reset holds against active commands.
        cycle(1, 'h82, 1, 'h5A, 1, 'h1234, 1, 1, "R1");
        cycle(1, 'h86, 1, 'h01, 0, 0, 0, 1, "R1");
        idle("R1");
        chk("R1 ptr_out reset", ptr_out, 0);
        chk("R1 ptr_sel reset", ptr_sel, 0);
        // R2: byte writes into both pointers, then read back.
        cycle(0, 'h82, 1, 'h34, 0, 0, 0, 0, "R2");
        cycle(0, 'h83, 1, 'h12, 0, 0, 0, 0, "R2");
        cycle(0, 'h84, 1, 'hCD, 0, 0, 0, 0, "R2");
        cycle(0, 'h85, 1, 'hAB, 0, 0, 0, 0, "R2");
        for (int a = 'h80; a <= 'h88; a++) idle("R2");
        for (int a = 'h80; a <= 'h88; a++) cycle(0, a, 0, 0, 0, 0, 0, 0, "R2");
        // R3: write 86h with upper bits set, read back.
        cycle(0, 'h86, 1, 'hFF, 0, 0, 0, 0, "R3");
        cycle(0, 'h86, 0, 0, 0, 0, 0, 0, "R3");
        cycle(0, 'h86, 1, 'hFE, 0, 0, 0, 0, "R3");
        cycle(0, 'h86, 0, 0, 0, 0, 0, 0, "R3");
        // R5: low-byte carry and full wrap on pointer 0.
        cycle(0, 'h82, 1, 'hFF, 0, 0, 0, 0, "R5");
        cycle(0, 'h00, 0, 0, 0, 0, 1, 0, "R5");
        cycle(0, 'h83, 1, 'hFF, 0, 0, 0, 0, "R5");
        cycle(0, 'h82, 1, 'hFF, 0, 0, 0, 0, "R5");
        cycle(0, 'h00, 0, 0, 0, 0, 1, 0, "R5");
        cycle(0, 'h84, 0, 0, 0, 0, 0, 0, "R5");
        // R7 / R6: toggle to pointer 1, load it, pointer 0 untouched.
        cycle(0, 'h00, 0, 0, 0, 0, 0, 1, "R7");
        cycle(0, 'h00, 0, 0, 1, 'hBEEF, 0, 0, "R6");
        cycle(0, 'h82, 0, 0, 0, 0, 0, 0, "R6");
        cycle(0, 'h85, 0, 0, 0, 0, 0, 0, "R6");
        // R8: unmapped writes change nothing.
        cycle(0, 'h81, 1, 'h77, 0, 0, 0, 0, "R8");
        cycle(0, 'h87, 1, 'h01, 0, 0, 0, 0, "R8");
        cycle(0, 'hFF, 1, 'h55, 0, 0, 0, 0, "R8");
        for (int a = 'h82; a <= 'h86; a++) cycle(0, a, 0, 0, 0, 0, 0, 0, "R8");
        // R9: collisions in one cycle.
        cycle(0, 'h84, 1, 'h11, 1, 'h4321, 1, 1, "R9");
        cycle(0, 'h82, 1, 'h22, 0, 0, 1, 0, "R9");
        cycle(0, 'h86, 1, 'h00, 0, 0, 1, 1, "R9");
        cycle(0, 'h83, 1, 'h99, 1, 'h0F0F, 0, 0, "R9");
        cycle(0, 'h85, 1, 'h66, 0, 0, 1, 1, "R9");
        idle("R9");
        // Mixed pseudo-random traffic.
        for (int n = 0; n < 3000; n++) begin
            int a;
            a = 'h80 + ($urandom % 9);
            cycle(0, a, ($urandom % 3) == 0, $urandom % 256, ($urandom % 8) == 0,
                  $urandom % 65536, ($urandom % 4) == 0, ($urandom % 6) == 0, "R9 mix");
        end
        idle("end");
        finish_run();
    end
endmodule